// File: doc/BRIEF.md
# Control-Transfer Alignment Checker

This unit sits next to the execute stage of a RISC-V style core. Each cycle it may receive one resolved instruction. The instruction is described by its kind, its own PC, the target computed for it, the branch outcome, its length, its link-register index and the current state of the compressed-instruction enable. From these the unit works out where fetch must go next. It decides whether that destination is an illegal fetch address and, when it is, raises an instruction-address-misaligned trap in place of the instruction's normal effect.

Legality follows the live compressed enable. With compressed instructions on, a halfword-aligned destination is accepted. With them off, the destination must be word aligned. An indirect jump clears the lowest bit of its computed target before the legality test. A plain sequential instruction is also checked: if compressed support has just been switched off while the PC sits on a halfword boundary, that fetch faults. For a trap return to a halfword-aligned saved PC, a build-time parameter chooses one of two policies. The unit either rounds the address down to a legal boundary or raises the same exception.

All results are registered and appear one cycle after the input. A trap replaces the next PC with the trap vector, blocks the link write and reports the faulting instruction's PC and address.

Top module: `xfer_align_unit`

## Requirements
- R1: For kind JALR (`in_kind`=2), bit 0 of the target is cleared before any use. An odd target by itself never traps, and the next PC is the target with bit 0 cleared.
- R2: When `in_c_en`=0, a JAL (1), JALR (2) or taken branch (3) whose effective target has bit 1 set traps. The trap sets `trap_valid`=1, `trap_cause`=`MISALIGN_CAUSE` (0 by default) and `next_pc` = the `trap_vec` value from the input cycle.
- R3: When `in_c_en`=1, an effective target with bit 1 set and bit 0 clear is legal. No trap is raised and `next_pc` equals that target.
- R4: JAL, JALR and taken branches pass through one and the same destination test. For JAL and a taken branch, a target with bit 0 set traps whatever the compressed enable is.
- R5: A branch whose `in_taken`=0 never traps, whatever its target. Its `next_pc` is `in_pc` + 2 when `in_len16`=1, and `in_pc` + 4 otherwise.
- R6: A non-faulting JAL or JALR with `in_rd`≠0 gives `rd_we`=1, `rd_idx`=`in_rd` and `rd_data` = `in_pc` + instruction length. A faulting jump, or `in_rd`=0, gives `rd_we`=0 with `rd_idx` and `rd_data` at 0.
- R7: On a trap, `trap_epc` is the PC of the instruction that faulted, not its target. Without a trap it is 0.
- R8: On a trap, `trap_tval` is the faulting address when `TVAL_ZERO`=0, and 0 when `TVAL_ZERO`=1. It is 0 when there is no trap.
- R9: A sequential instruction (`in_kind`=0) traps when `in_c_en`=0 and `in_pc` bit 1 is set, with the faulting address equal to `in_pc`. Otherwise its `next_pc` is `in_pc` + length.
- R10: For a trap return (`in_kind`=4) to a misaligned address, `TRET_ALIGN`=1 rounds the address down: bit 0 is cleared, and bit 1 as well when `in_c_en`=0. No trap is raised. `TRET_ALIGN`=0 traps instead.
- R11: Outputs are registered with one cycle of latency. A cycle with `in_valid`=0 gives `out_valid`=0, `trap_valid`=0 and `rd_we`=0, and `next_pc` keeps its value.
- R12: Synchronous reset clears every output to 0, with `next_pc` set to `RESET_PC` (0 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A resolved instruction is present |
| in_kind | input | 3 | 0 sequential, 1 JAL, 2 JALR, 3 branch, 4 trap return |
| in_pc | input | XLEN | PC of the instruction |
| in_target | input | XLEN | Computed target (saved PC for trap return) |
| in_taken | input | 1 | Branch outcome |
| in_len16 | input | 1 | Instruction is 16 bits long |
| in_rd | input | REG_AW | Link register index |
| in_c_en | input | 1 | Compressed instructions currently enabled |
| trap_vec | input | XLEN | Trap handler address |
| out_valid | output | 1 | Registered result present |
| next_pc | output | XLEN | Next fetch address |
| trap_valid | output | 1 | Misaligned-fetch trap, one cycle per faulting instruction |
| trap_cause | output | CAUSE_W | Trap cause code |
| trap_epc | output | XLEN | PC of the faulting instruction |
| trap_tval | output | XLEN | Faulting address or zero |
| rd_we | output | 1 | Link register write enable |
| rd_idx | output | REG_AW | Link register index |
| rd_data | output | XLEN | Link value |

## Verification
The assertions assume that `in_kind` only takes the codes 0 to 4, and that each input cycle is a fully resolved instruction whose own PC has bit 0 clear. The random stimulus draws its kinds only from those five codes and clears bit 0 of every generated PC. The target, the compressed enable, the taken flag, the length and the link index are drawn freely, so that every alignment pattern occurs. Two instances with opposite policy parameters receive the same stream, which covers both trap-return behaviours and both choices for the faulting-address output.

// File: rtl/xfer_align_pkg.sv
package xfer_align_pkg;
  typedef enum logic [2:0] {
    XK_SEQ  = 3'd0,
    XK_JAL  = 3'd1,
    XK_JALR = 3'd2,
    XK_BR   = 3'd3,
    XK_TRET = 3'd4
  } xfer_kind_e;
endpackage

// File: rtl/xfer_target_calc.sv
module xfer_target_calc
  import xfer_align_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  xfer_kind_e       kind,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  target,
  input  logic             taken,
  input  logic             len16,
  output logic [XLEN-1:0]  eff_tgt,
  output logic [XLEN-1:0]  fallthru,
  output logic             redirect
);
  always_comb begin
    fallthru = pc + (len16 ? XLEN'(2) : XLEN'(4));
    eff_tgt  = fallthru;
    redirect = 1'b0;
    case (kind)
      XK_JAL:  begin eff_tgt = target;                    redirect = 1'b1; end
      XK_JALR: begin eff_tgt = {target[XLEN-1:1], 1'b0};  redirect = 1'b1; end
      XK_BR:   if (taken) begin eff_tgt = target;         redirect = 1'b1; end
      XK_TRET: begin eff_tgt = target;                    redirect = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/xfer_fault_detect.sv
module xfer_fault_detect
  import xfer_align_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit TRET_ALIGN = 1'b1
) (
  input  xfer_kind_e       kind,
  input  logic             redirect,
  input  logic [XLEN-1:0]  eff_tgt,
  input  logic [XLEN-1:0]  pc,
  input  logic             c_en,
  output logic             fault,
  output logic [XLEN-1:0]  fault_addr,
  output logic [XLEN-1:0]  dest
);
  logic            bad_tgt;
  logic            tret_round;
  logic [XLEN-1:0] round_mask;

  assign bad_tgt    = eff_tgt[0] | (eff_tgt[1] & ~c_en);
  assign round_mask = ~{{(XLEN-2){1'b0}}, ~c_en, 1'b1};

  generate
    if (TRET_ALIGN) begin : g_round
      assign tret_round = 1'b1;
    end else begin : g_raise
      assign tret_round = 1'b0;
    end
  endgenerate

  always_comb begin
    fault      = 1'b0;
    fault_addr = eff_tgt;
    dest       = eff_tgt;
    case (kind)
      XK_JAL, XK_JALR, XK_BR: fault = redirect & bad_tgt;
      XK_TRET: begin
        if (bad_tgt) begin
          if (tret_round) dest  = eff_tgt & round_mask;
          else            fault = 1'b1;
        end
      end
      default: begin
        fault      = pc[1] & ~c_en;
        fault_addr = pc;
      end
    endcase
  end
endmodule

// File: rtl/xfer_align_unit.sv
module xfer_align_unit
  import xfer_align_pkg::*;
#(
  parameter int          XLEN           = 32,
  parameter int          REG_AW         = 5,
  parameter int          CAUSE_W        = 6,
  parameter int          MISALIGN_CAUSE = 0,
  parameter bit          TRET_ALIGN     = 1'b1,
  parameter bit          TVAL_ZERO      = 1'b0,
  parameter logic [31:0] RESET_PC       = 32'h0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [2:0]         in_kind,
  input  logic [XLEN-1:0]    in_pc,
  input  logic [XLEN-1:0]    in_target,
  input  logic               in_taken,
  input  logic               in_len16,
  input  logic [REG_AW-1:0]  in_rd,
  input  logic               in_c_en,
  input  logic [XLEN-1:0]    trap_vec,
  output logic               out_valid,
  output logic [XLEN-1:0]    next_pc,
  output logic               trap_valid,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [XLEN-1:0]    trap_epc,
  output logic [XLEN-1:0]    trap_tval,
  output logic               rd_we,
  output logic [REG_AW-1:0]  rd_idx,
  output logic [XLEN-1:0]    rd_data
);
  localparam logic [CAUSE_W-1:0] CAUSE_CODE = CAUSE_W'(MISALIGN_CAUSE);
  localparam logic [XLEN-1:0]    PC_INIT    = XLEN'(RESET_PC);

  xfer_kind_e      kind;
  logic [XLEN-1:0] eff_tgt, fallthru, fault_addr, dest;
  logic            redirect, fault, link_ok;

  assign kind = xfer_kind_e'(in_kind);

  xfer_target_calc #(.XLEN(XLEN)) u_calc (
    .kind     (kind),
    .pc       (in_pc),
    .target   (in_target),
    .taken    (in_taken),
    .len16    (in_len16),
    .eff_tgt  (eff_tgt),
    .fallthru (fallthru),
    .redirect (redirect)
  );

  xfer_fault_detect #(.XLEN(XLEN), .TRET_ALIGN(TRET_ALIGN)) u_fault (
    .kind       (kind),
    .redirect   (redirect),
    .eff_tgt    (eff_tgt),
    .pc         (in_pc),
    .c_en       (in_c_en),
    .fault      (fault),
    .fault_addr (fault_addr),
    .dest       (dest)
  );

  assign link_ok = (kind == XK_JAL || kind == XK_JALR) && !fault && (in_rd != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      next_pc    <= PC_INIT;
      trap_valid <= 1'b0;
      trap_cause <= '0;
      trap_epc   <= '0;
      trap_tval  <= '0;
      rd_we      <= 1'b0;
      rd_idx     <= '0;
      rd_data    <= '0;
    end else begin
      out_valid  <= in_valid;
      trap_valid <= in_valid && fault;
      trap_cause <= '0;
      trap_epc   <= '0;
      trap_tval  <= '0;
      rd_we      <= 1'b0;
      rd_idx     <= '0;
      rd_data    <= '0;
      if (in_valid) begin
        if (fault) begin
          next_pc    <= trap_vec;
          trap_cause <= CAUSE_CODE;
          trap_epc   <= in_pc;
          trap_tval  <= TVAL_ZERO ? '0 : fault_addr;
        end else begin
          next_pc <= dest;
        end
        if (link_ok) begin
          rd_we   <= 1'b1;
          rd_idx  <= in_rd;
          rd_data <= fallthru;
        end
      end
    end
  end
endmodule

// File: rtl/xfer_align_chk.sv
module xfer_align_chk #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        in_kind,
  input logic [XLEN-1:0]   in_pc,
  input logic [XLEN-1:0]   in_target,
  input logic              in_taken,
  input logic              in_c_en,
  input logic [XLEN-1:0]   trap_vec,
  input logic              out_valid,
  input logic [XLEN-1:0]   next_pc,
  input logic              trap_valid,
  input logic [XLEN-1:0]   trap_epc,
  input logic              rd_we,
  input logic [REG_AW-1:0] rd_idx
);
  a_r6_no_link_on_trap: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> !rd_we);

  a_r2_vector_taken: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> next_pc == $past(trap_vec));

  a_r5_not_taken_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_kind == 3'd3 && !in_taken) |-> !trap_valid);

  a_r1_jalr_c_on_legal: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_kind == 3'd2 && in_c_en) |-> !trap_valid);

  a_r3_jal_even_c_on: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_kind == 3'd1 && in_c_en && !in_target[0]) |-> !trap_valid);

  a_r7_epc_is_pc: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> trap_epc == $past(in_pc));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!trap_valid && !rd_we && rd_idx == '0));
endmodule

bind xfer_align_unit xfer_align_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_kind    (in_kind),
  .in_pc      (in_pc),
  .in_target  (in_target),
  .in_taken   (in_taken),
  .in_c_en    (in_c_en),
  .trap_vec   (trap_vec),
  .out_valid  (out_valid),
  .next_pc    (next_pc),
  .trap_valid (trap_valid),
  .trap_epc   (trap_epc),
  .rd_we      (rd_we),
  .rd_idx     (rd_idx)
);

// File: tb/xfer_align_unit_test.sv
module xfer_align_unit_test;
  localparam int XLEN = 32;
  localparam int RW   = 5;

  typedef struct packed {
    logic            ov;
    logic [XLEN-1:0] npc;
    logic            tv;
    logic [5:0]      cause;
    logic [XLEN-1:0] epc;
    logic [XLEN-1:0] tval;
    logic            we;
    logic [RW-1:0]   idx;
    logic [XLEN-1:0] data;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [2:0]      in_kind = '0;
  logic [XLEN-1:0] in_pc = '0, in_target = '0, trap_vec = 32'h0000_8000;
  logic            in_taken = 1'b0, in_len16 = 1'b0, in_c_en = 1'b1;
  logic [RW-1:0]   in_rd = '0;

  exp_t got_a, got_b;
  logic [XLEN-1:0] hold_a = '0, hold_b = '0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xfer_align_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_pc(in_pc),
    .in_target(in_target), .in_taken(in_taken), .in_len16(in_len16), .in_rd(in_rd),
    .in_c_en(in_c_en), .trap_vec(trap_vec), .out_valid(got_a.ov), .next_pc(got_a.npc),
    .trap_valid(got_a.tv), .trap_cause(got_a.cause), .trap_epc(got_a.epc),
    .trap_tval(got_a.tval), .rd_we(got_a.we), .rd_idx(got_a.idx), .rd_data(got_a.data));

  xfer_align_unit #(.TRET_ALIGN(1'b0), .TVAL_ZERO(1'b1)) uut_alt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_pc(in_pc),
    .in_target(in_target), .in_taken(in_taken), .in_len16(in_len16), .in_rd(in_rd),
    .in_c_en(in_c_en), .trap_vec(trap_vec), .out_valid(got_b.ov), .next_pc(got_b.npc),
    .trap_valid(got_b.tv), .trap_cause(got_b.cause), .trap_epc(got_b.epc),
    .trap_tval(got_b.tval), .rd_we(got_b.we), .rd_idx(got_b.idx), .rd_data(got_b.data));

  function automatic exp_t model(bit round_tret, bit zero_tval, logic [XLEN-1:0] prev);
    exp_t e;
    logic [XLEN-1:0] ft, dst, fa, t;
    logic flt, mis;
    e  = '0;
    ft = in_pc + (in_len16 ? 32'd2 : 32'd4);
    dst = ft; fa = '0; flt = 1'b0;
    case (in_kind)
      3'd1, 3'd3: begin
        if (in_kind == 3'd1 || in_taken) begin
          dst = in_target; fa = in_target;
          flt = in_target[0] || (in_target[1] && !in_c_en);
        end
      end
      3'd2: begin
        t = in_target & ~32'd1;
        dst = t; fa = t; flt = t[1] && !in_c_en;
      end
      3'd4: begin
        mis = in_target[0] || (in_target[1] && !in_c_en);
        dst = in_target; fa = in_target;
        if (mis && round_tret) dst = in_target & (in_c_en ? ~32'd1 : ~32'd3);
        else if (mis) flt = 1'b1;
      end
      default: begin
        fa = in_pc; flt = in_pc[1] && !in_c_en;
      end
    endcase
    if (!in_valid) begin
      e.npc = prev;
      return e;
    end
    e.ov = 1'b1;
    e.tv = flt;
    e.npc = flt ? trap_vec : dst;
    if (flt) begin
      e.epc = in_pc;
      e.tval = zero_tval ? '0 : fa;
    end
    if ((in_kind == 3'd1 || in_kind == 3'd2) && !flt && in_rd != '0) begin
      e.we = 1'b1; e.idx = in_rd; e.data = ft;
    end
    return e;
  endfunction

  task automatic compare(string req, exp_t got, exp_t exp, string inst);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual ov=%b npc=%h tv=%b cause=%0d epc=%h tval=%h we=%b idx=%0d data=%h expected ov=%b npc=%h tv=%b cause=%0d epc=%h tval=%h we=%b idx=%0d data=%h",
        req, inst, got.ov, got.npc, got.tv, got.cause, got.epc, got.tval, got.we, got.idx, got.data,
        exp.ov, exp.npc, exp.tv, exp.cause, exp.epc, exp.tval, exp.we, exp.idx, exp.data);
    end
  endtask

  task automatic step(string req, logic v, logic [2:0] k, logic [XLEN-1:0] pc,
                      logic [XLEN-1:0] tg, logic tk, logic l16, logic [RW-1:0] rd, logic ce);
    exp_t ea, eb;
    in_valid = v; in_kind = k; in_pc = pc; in_target = tg;
    in_taken = tk; in_len16 = l16; in_rd = rd; in_c_en = ce;
    ea = model(1'b1, 1'b0, hold_a);
    eb = model(1'b0, 1'b1, hold_b);
    @(posedge clk); #1;
    compare(req, got_a, ea, "round");
    compare(req, got_b, eb, "raise");
    hold_a = ea.npc; hold_b = eb.npc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    exp_t z;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    z = '0;
    compare("R12 reset", got_a, z, "round");
    compare("R12 reset", got_b, z, "raise");
    step("R1 odd jalr target c off", 1, 3'd2, 32'h100, 32'h201, 0, 0, 5'd1, 0);
    step("R1 odd jalr halfword c on", 1, 3'd2, 32'h104, 32'h203, 0, 0, 5'd2, 1);
    step("R2 jalr halfword c off traps", 1, 3'd2, 32'h108, 32'h203, 0, 0, 5'd2, 0);
    step("R2 R6 jal traps no link", 1, 3'd1, 32'h10C, 32'h206, 0, 0, 5'd1, 0);
    step("R3 jal halfword c on", 1, 3'd1, 32'h110, 32'h206, 0, 0, 5'd3, 1);
    step("R4 taken branch halfword c off", 1, 3'd3, 32'h114, 32'h30A, 1, 0, 5'd0, 0);
    step("R4 jal odd target c on", 1, 3'd1, 32'h118, 32'h301, 0, 1, 5'd4, 1);
    step("R5 not taken branch", 1, 3'd3, 32'h11C, 32'h30B, 0, 0, 5'd0, 0);
    step("R5 not taken short branch", 1, 3'd3, 32'h122, 32'h30A, 0, 1, 5'd0, 1);
    step("R6 jal rd zero", 1, 3'd1, 32'h124, 32'h400, 0, 0, 5'd0, 0);
    step("R7 R8 epc tval on branch", 1, 3'd3, 32'h128, 32'h502, 1, 0, 5'd0, 0);
    step("R9 seq halfword pc c off", 1, 3'd0, 32'h402, 32'h0, 0, 0, 5'd0, 0);
    step("R9 seq halfword pc c on", 1, 3'd0, 32'h402, 32'h0, 0, 1, 5'd0, 1);
    step("R10 tret halfword c off", 1, 3'd4, 32'h130, 32'h506, 0, 0, 5'd0, 0);
    step("R10 tret odd c on", 1, 3'd4, 32'h134, 32'h507, 0, 0, 5'd0, 1);
    step("R10 tret aligned", 1, 3'd4, 32'h138, 32'h600, 0, 0, 5'd0, 0);
    step("R11 idle holds", 0, 3'd1, 32'h13C, 32'h702, 0, 0, 5'd7, 0);
    step("R11 idle again", 0, 3'd0, 32'h140, 32'h0, 0, 0, 5'd0, 1);
    for (int i = 0; i < 600; i++) begin
      step("R2 R3 R4 R6 R11 random",
           ($urandom % 8) != 0, 3'($urandom % 5), $urandom & ~32'd1, $urandom,
           1'($urandom), 1'($urandom), 5'($urandom), 1'($urandom));
    end
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    compare("R12 reset again", got_a, z, "round");
    compare("R12 reset again", got_b, z, "raise");
    hold_a = '0; hold_b = '0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule